// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is one bank of 32 general-purpose lines. Each line can be an input or an output. A small register file, reached through a valid/write strobe, sets the direction and the output value of each line and returns what the pin carries. The line number inside the bank is the low five bits of a global line number. The bits above those five select the bank, and that selection happens outside this block.

Every input passes through a two-stage synchroniser. The bank then watches each line for one of five conditions: a rising edge, a falling edge, either edge, a high level or a low level. Three type bits per line choose the condition. When the condition occurs on an enabled line, a sticky status bit is set. Software clears a status bit by writing 1 to it. A single `irq` output is high while any line has its status bit set and its enable bit set.

The bus has two register groups, selected by `bus_grp`. Group 0 holds the output value and the direction. Group 1 holds the enable, the three type registers and the status. A read returns data in the same cycle through a combinational path.

Top module: `gpio_sense_bank`

## Requirements
- R1: After reset, every register reads 0, `pin_out` and `pin_oe` are 0 and `irq` is low.
- R2: Group 0 (`bus_grp`=0) uses these offsets:
  - 0x00: output value.
  - 0x04: direction, where 1 means output.
  - `pin_oe` follows the direction register. `pin_out` follows the output-value register.
- R3: A read of group 0 offset 0x00 returns, for each line, the output value if the line is an output, or the synchronised pin value if the line is an input.
- R4: Edge sensing uses the per-line code (t2,t1,t0):
  - 000 selects the falling edge.
  - 001 selects the rising edge.
  - 1x0 and 101 with t1=0 select either edge.
  - When a pin changes just after a clock edge, its status bit reads set after the third rising clock edge that follows.
- R5: Any code with t1=1 selects level sensing, whatever t2 holds:
  - t0=1 senses a high level.
  - t0=0 senses a low level.
- R6: Group 1 (`bus_grp`=1) uses these offsets:
  - 0x00: enable.
  - 0x04: t0.
  - 0x08: t1.
  - 0x0C: t2.
  - 0x10: status.
  - The enable and type registers read back all 32 bits as written.
- R7: A status bit latches only while its line is enabled. A condition on a disabled line leaves status unchanged.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A level-sensed line whose level is still active stays set.
- R9: When a new event and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R10: `irq` is the OR over all lines of status AND enable. Clearing an enable bit masks that line's interrupt without clearing its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_grp | input | 1 | Register group: 0 port, 1 interrupt |
| bus_addr | input | 5 | Byte offset within the group |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
A clearing write to the status register and a newly detected event on the same line can land on the same clock edge. The bench provokes this on a rising-edge line that already has its status bit set. It raises the pin so that the synchronised edge appears in exactly the cycle in which the clearing write takes effect. It then reads status and expects the bit to be set, so a design that lets the clear win is caught. A level-high line cleared while its pin is still high exercises the same overlap from the level side.

// File: rtl/gpio_sense_bank.sv
module gpio_sense_bank #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_grp,
  input  logic [4:0]        bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq
);
  localparam logic [4:0] OFS_DATA = 5'h00, OFS_DIR = 5'h04;
  localparam logic [4:0] OFS_EN = 5'h00, OFS_T0 = 5'h04, OFS_T1 = 5'h08,
                         OFS_T2 = 5'h0c, OFS_ST = 5'h10;

  logic [NLINES-1:0] out_q, dir_q, en_q, t0_q, t1_q, t2_q, st_q;
  logic [NLINES-1:0] sy1_q, sy2_q, old_q;
  logic [NLINES-1:0] rise, fall, lvl_hit, edg_hit, hit, ack;
  logic              wr;

  assign wr = bus_valid & bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
      old_q <= '0;
    end else begin
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
      old_q <= sy2_q;
    end
  end

  assign rise    = sy2_q & ~old_q;
  assign fall    = ~sy2_q & old_q;
  assign lvl_hit = (t0_q & sy2_q) | (~t0_q & ~sy2_q);
  assign edg_hit = (t2_q & (rise | fall)) |
                   (~t2_q & ((t0_q & rise) | (~t0_q & fall)));
  assign hit     = (t1_q & lvl_hit) | (~t1_q & edg_hit);
  assign ack     = (wr && bus_grp && bus_addr == OFS_ST) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      en_q  <= '0;
      t0_q  <= '0;
      t1_q  <= '0;
      t2_q  <= '0;
    end else if (wr) begin
      if (!bus_grp) begin
        if (bus_addr == OFS_DATA) out_q <= bus_wdata;
        if (bus_addr == OFS_DIR)  dir_q <= bus_wdata;
      end else begin
        if (bus_addr == OFS_EN) en_q <= bus_wdata;
        if (bus_addr == OFS_T0) t0_q <= bus_wdata;
        if (bus_addr == OFS_T1) t1_q <= bus_wdata;
        if (bus_addr == OFS_T2) t2_q <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~ack) | (hit & en_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_grp) begin
      case (bus_addr)
        OFS_DATA: bus_rdata = (dir_q & out_q) | (~dir_q & sy2_q);
        OFS_DIR:  bus_rdata = dir_q;
        default:  bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        OFS_EN:  bus_rdata = en_q;
        OFS_T0:  bus_rdata = t0_q;
        OFS_T1:  bus_rdata = t1_q;
        OFS_T2:  bus_rdata = t2_q;
        OFS_ST:  bus_rdata = st_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(st_q & en_q);

  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && !bus_grp && bus_addr == OFS_DIR) |=> $stable(pin_oe)); // R2
  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~hit) != '0) |=> ((st_q & $past(ack & ~hit)) == '0)); // R8
  AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & hit & en_q) != '0) |=> ((st_q & $past(ack & hit & en_q)) == $past(ack & hit & en_q))); // R9
  AST_NO_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R10
endmodule

// File: tb/gpio_sense_bank_test.sv
`timescale 1ns/1ps
module gpio_sense_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_grp = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic        irq;

  gpio_sense_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_grp(bus_grp), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic chk_req = 1'b0;
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (chk_req && kind_q.size() > 0) begin
      int k;
      logic [31:0] e, a;
      string t;
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      case (k)
        0: a = bus_rdata;
        1: a = {31'b0, irq};
        2: a = pin_out;
        default: a = pin_oe;
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic expect_val(input int k, input logic g, input logic [4:0] ad,
                            input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_grp = g; bus_addr = ad; bus_valid = 1'b0;
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  task automatic rd(input logic g, input logic [4:0] ad, input logic [31:0] e, input string t);
    expect_val(0, g, ad, e, t);
  endtask

  task automatic wr(input logic g, input logic [4:0] ad, input logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_grp = g; bus_addr = ad; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic pins(input logic [31:0] v);
    @(posedge clk); #1;
    pin_in = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(0, 5'h00, 32'h0, "R1 data");
    rd(0, 5'h04, 32'h0, "R1 dir");
    rd(1, 5'h00, 32'h0, "R1 enable");
    rd(1, 5'h04, 32'h0, "R1 t0");
    rd(1, 5'h08, 32'h0, "R1 t1");
    rd(1, 5'h0c, 32'h0, "R1 t2");
    rd(1, 5'h10, 32'h0, "R1 status");
    expect_val(1, 0, 0, 32'h0, "R1 irq");
    expect_val(3, 0, 0, 32'h0, "R1 pin_oe");

    wr(0, 5'h04, 32'h0000_00FF);
    wr(0, 5'h00, 32'h0000_00A5);
    pins(32'h1300_005A);
    settle();
    rd(0, 5'h00, 32'h1300_00A5, "R3 mixed data read");
    expect_val(2, 0, 0, 32'h0000_00A5, "R2 pin_out");
    expect_val(3, 0, 0, 32'h0000_00FF, "R2 pin_oe");
    rd(0, 5'h04, 32'h0000_00FF, "R2 dir readback");
    wr(0, 5'h04, 32'h0);
    wr(0, 5'h00, 32'h0);
    pins(32'h0);
    settle();

    wr(1, 5'h04, 32'hDEAD_BEEF);
    rd(1, 5'h04, 32'hDEAD_BEEF, "R6 t0 readback");
    wr(1, 5'h08, 32'h1234_5678);
    rd(1, 5'h08, 32'h1234_5678, "R6 t1 readback");
    wr(1, 5'h04, 32'h0);
    wr(1, 5'h08, 32'h0);

    // R4 falling edge on line 1
    pins(32'h0000_0002);
    settle();
    wr(1, 5'h00, 32'h0000_0002);
    rd(1, 5'h10, 32'h0, "R4 no falling edge yet");
    pins(32'h0);
    settle();
    rd(1, 5'h10, 32'h0000_0002, "R4 falling edge latched");
    expect_val(1, 0, 0, 32'h1, "R10 irq raised");

    wr(1, 5'h10, 32'h0);
    rd(1, 5'h10, 32'h0000_0002, "R8 zero write no effect");
    wr(1, 5'h10, 32'h0000_0002);
    rd(1, 5'h10, 32'h0, "R8 ack clears");
    expect_val(1, 0, 0, 32'h0, "R10 irq dropped");

    // R4 rising edge on line 2
    wr(1, 5'h04, 32'h0000_0004);
    wr(1, 5'h00, 32'h0000_0006);
    pins(32'h0000_0004);
    settle();
    rd(1, 5'h10, 32'h0000_0004, "R4 rising edge latched");
    wr(1, 5'h10, 32'h0000_0004);
    pins(32'h0);
    settle();
    rd(1, 5'h10, 32'h0, "R4 falling ignored in rising mode");

    // R4 either edge on line 3
    wr(1, 5'h04, 32'h0000_000C);
    wr(1, 5'h0c, 32'h0000_0008);
    wr(1, 5'h00, 32'h0000_000E);
    pins(32'h0000_0008);
    settle();
    rd(1, 5'h10, 32'h0000_0008, "R4 both-edge rise");
    wr(1, 5'h10, 32'h0000_0008);
    pins(32'h0);
    settle();
    rd(1, 5'h10, 32'h0000_0008, "R4 both-edge fall");
    wr(1, 5'h10, 32'h0000_0008);

    // R5 high level on line 4
    wr(1, 5'h04, 32'h0000_001C);
    wr(1, 5'h08, 32'h0000_0010);
    wr(1, 5'h00, 32'h0000_001E);
    rd(1, 5'h10, 32'h0, "R5 high level idle");
    pins(32'h0000_0010);
    settle();
    rd(1, 5'h10, 32'h0000_0010, "R5 high level latched");
    wr(1, 5'h10, 32'h0000_0010);
    rd(1, 5'h10, 32'h0000_0010, "R8 level still active re-sets");
    pins(32'h0);
    settle();
    wr(1, 5'h10, 32'h0000_0010);
    rd(1, 5'h10, 32'h0, "R8 level gone, ack clears");

    // R5 low level on line 5
    wr(1, 5'h08, 32'h0000_0030);
    wr(1, 5'h00, 32'h0000_003E);
    rd(1, 5'h10, 32'h0000_0020, "R5 low level latched");
    pins(32'h0000_0020);
    settle();
    wr(1, 5'h10, 32'h0000_0020);
    rd(1, 5'h10, 32'h0, "R5 low level released");

    // R7 disabled line 6, rising mode
    wr(1, 5'h04, 32'h0000_005C);
    pins(32'h0000_0060);
    settle();
    rd(1, 5'h10, 32'h0, "R7 disabled line ignored");
    expect_val(1, 0, 0, 32'h0, "R7 irq stays low");

    // R10 masking keeps status
    pins(32'h0000_0070);
    settle();
    rd(1, 5'h10, 32'h0000_0010, "R10 level set before mask");
    expect_val(1, 0, 0, 32'h1, "R10 irq high before mask");
    wr(1, 5'h00, 32'h0000_002E);
    expect_val(1, 0, 0, 32'h0, "R10 irq masked");
    rd(1, 5'h10, 32'h0000_0010, "R10 status kept while masked");
    pins(32'h0000_0060);
    settle();
    wr(1, 5'h00, 32'h0000_003E);
    wr(1, 5'h10, 32'h0000_0010);
    rd(1, 5'h10, 32'h0, "R10 cleanup");

    // R9 event and ack on the same edge, line 2
    pins(32'h0000_0064);
    settle();
    rd(1, 5'h10, 32'h0000_0004, "R9 prior event set");
    pins(32'h0000_0060);
    settle();
    pins(32'h0000_0064);
    @(posedge clk);
    wr(1, 5'h10, 32'h0000_0004);
    rd(1, 5'h10, 32'h0000_0004, "R9 new event beats ack");
    wr(1, 5'h10, 32'h0000_0004);
    rd(1, 5'h10, 32'h0, "R9 later ack clears");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule